// File: doc/BRIEF.md
# CAVLC Block Bitstream Packer

This block assembles the coded bits of one 4x4 residual block into a single serial bitstream. Code words arrive on four handshaked input groups: the coefficient token (with its total-coefficient count, trailing-one count and the trailing-one sign bits), level codes, the total-zeros code, and run-before codes. A sequencer accepts the groups strictly in the coding order. It works out from the token how many level codes, whether a total-zeros code and how many run codes the block holds. Each accepted code becomes one right-aligned parallel word with a length.

A serializer shifts each parallel word out MSB first into a bit FIFO. The downstream channel drains the FIFO with a valid/ready pair. A halt input freezes the serializer for rate control. Backpressure from halt or from a full FIFO reaches the input groups through their ready signals, so no bit is lost or reordered.

Top module: `cavlc_stream_packer`

## Requirements
- R1: After reset, no bit and no parallel word is presented, `tok_ready_o` is 1 and the other three input readies are 0.
- R2: Each block's bits leave in this order: token code, trailing-one signs, level codes in arrival order (highest frequency first), total-zeros code, run codes. Every field contributes exactly its given length, MSB first, with no padding.
- R3: The sign field is the low `tok_t1_i` bits of `tok_sign_i`, sent from bit `tok_t1_i-1` down to bit 0. It is left out when `tok_t1_i` is 0.
- R4: A level code is `lvl_pre_len_i` zeros, then a single one, then the low `lvl_suf_len_i` bits of `lvl_suffix_i`, MSB first. Higher suffix bits are ignored. Exactly `tok_total_i - tok_t1_i` level codes are taken per block.
- R5: The total-zeros code is taken only when the total coefficient count is non-zero and below `MAX_COEFF` (16). A block with count 0 is the token alone. A block with count 16 ends after its levels.
- R6: Run codes are taken only while the zeros not yet coded (starting at `tz_value_i` and reduced by each `run_value_i`) are non-zero and more than one coefficient remains. Otherwise the next block's token is awaited.
- R7: Every code word appears once on `par_data_o`/`par_len_o` with `par_valid_o` for one cycle, right-aligned, with length 1 to `PAR_W`. Two words are never presented in consecutive cycles.
- R8: While `halt_i` is 1 no bit enters the FIFO, and the held bits leave intact once halt drops.
- R9: When the FIFO is full the serializer holds its bit and the inputs stall. The FIFO never holds more than `FIFO_DEPTH` bits, and the stream after draining is complete and in order.
- R10: At most one input ready is asserted in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tok_valid_i | input | 1 | Token group valid |
| tok_ready_o | output | 1 | Token group accepted |
| tok_code_i | input | TOK_W (16) | Token code bits, right-aligned |
| tok_len_i | input | 5 | Token code length |
| tok_total_i | input | CW (5) | Total non-zero coefficients of the block |
| tok_t1_i | input | 2 | Trailing-one count (0..3) |
| tok_sign_i | input | 3 | Trailing-one signs, 1 = negative |
| lvl_valid_i | input | 1 | Level group valid |
| lvl_ready_o | output | 1 | Level group accepted |
| lvl_pre_len_i | input | 4 | Number of prefix zeros |
| lvl_suf_len_i | input | 4 | Number of suffix bits |
| lvl_suffix_i | input | SUF_W (13) | Suffix bits, right-aligned |
| tz_valid_i | input | 1 | Total-zeros group valid |
| tz_ready_o | output | 1 | Total-zeros group accepted |
| tz_code_i | input | TZ_W (9) | Total-zeros code, right-aligned |
| tz_len_i | input | 4 | Total-zeros code length |
| tz_value_i | input | ZW (4) | Total-zeros value |
| run_valid_i | input | 1 | Run group valid |
| run_ready_o | output | 1 | Run group accepted |
| run_code_i | input | RUN_W (11) | Run code, right-aligned |
| run_len_i | input | 4 | Run code length |
| run_value_i | input | ZW (4) | Run-before value |
| halt_i | input | 1 | Stall the serializer |
| par_valid_o | output | 1 | Parallel word taken by the serializer |
| par_data_o | output | PAR_W (21) | Parallel word, right-aligned |
| par_len_o | output | LEN_W (5) | Parallel word length |
| bit_o | output | 1 | Serial output bit |
| bit_valid_o | output | 1 | Serial bit available |
| bit_ready_i | input | 1 | Downstream takes the serial bit |

## Verification
The main pattern is a five-coefficient block with three trailing ones, two level codes and four run codes. It is compared bit for bit with a 25-bit stream and a nine-word parallel sequence, which exposes any reordering, dropped field or length slip. Edge blocks separate the skip rules. These are an empty block, a block with sixteen coefficients and no zeros field, a block whose total zeros are 0 so no runs follow, and a level whose suffix input carries extra high bits that must be masked. Halt and a full FIFO are each applied while a block is in flight, which tells a design that stalls correctly from one that drops or duplicates bits.

// File: rtl/cavlc_pack_pkg.sv
package cavlc_pack_pkg;
  typedef enum logic [2:0] {
    ST_TOK, ST_SGN, ST_LVL, ST_TZ, ST_RUN
  } seq_state_e;
endpackage

// File: rtl/cavlc_field_seq.sv
module cavlc_field_seq
  import cavlc_pack_pkg::*;
#(
  parameter int PAR_W     = 21,
  parameter int LEN_W     = 5,
  parameter int MAX_COEFF = 16,
  parameter int TOK_W     = 16,
  parameter int SUF_W     = 13,
  parameter int TZ_W      = 9,
  parameter int RUN_W     = 11,
  localparam int CW       = $clog2(MAX_COEFF + 1),
  localparam int ZW       = $clog2(MAX_COEFF)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tok_valid_i,
  output logic             tok_ready_o,
  input  logic [TOK_W-1:0] tok_code_i,
  input  logic [4:0]       tok_len_i,
  input  logic [CW-1:0]    tok_total_i,
  input  logic [1:0]       tok_t1_i,
  input  logic [2:0]       tok_sign_i,
  input  logic             lvl_valid_i,
  output logic             lvl_ready_o,
  input  logic [3:0]       lvl_pre_len_i,
  input  logic [3:0]       lvl_suf_len_i,
  input  logic [SUF_W-1:0] lvl_suffix_i,
  input  logic             tz_valid_i,
  output logic             tz_ready_o,
  input  logic [TZ_W-1:0]  tz_code_i,
  input  logic [3:0]       tz_len_i,
  input  logic [ZW-1:0]    tz_value_i,
  input  logic             run_valid_i,
  output logic             run_ready_o,
  input  logic [RUN_W-1:0] run_code_i,
  input  logic [3:0]       run_len_i,
  input  logic [ZW-1:0]    run_value_i,
  output logic             word_valid_o,
  input  logic             word_ready_i,
  output logic [PAR_W-1:0] word_data_o,
  output logic [LEN_W-1:0] word_len_o
);
  seq_state_e       state_q;
  logic [CW-1:0]    total_q, lvl_left_q, coef_left_q;
  logic [1:0]       t1_q;
  logic [2:0]       sign_q;
  logic [ZW-1:0]    zeros_q;
  logic             can_load;
  logic [31:0]      lvl_word;
  logic [ZW-1:0]    zeros_nx;
  logic [CW-1:0]    coef_nx;
  logic [2:0]       sign_mask;

  // state after the sign field, given levels pending and coefficient count
  function automatic seq_state_e after_sign(logic [CW-1:0] left, logic [CW-1:0] total);
    if (total == '0)                  return ST_TOK;
    else if (left != '0)              return ST_LVL;
    else if (total < CW'(MAX_COEFF))  return ST_TZ;
    else                              return ST_TOK;
  endfunction

  assign can_load    = !word_valid_o || word_ready_i;
  assign tok_ready_o = (state_q == ST_TOK) && can_load;
  assign lvl_ready_o = (state_q == ST_LVL) && can_load;
  assign tz_ready_o  = (state_q == ST_TZ)  && can_load;
  assign run_ready_o = (state_q == ST_RUN) && can_load;

  assign lvl_word  = (32'd1 << lvl_suf_len_i)
                   | (32'(lvl_suffix_i) & ((32'd1 << lvl_suf_len_i) - 32'd1));
  assign zeros_nx  = zeros_q - run_value_i;
  assign coef_nx   = coef_left_q - CW'(1);
  assign sign_mask = (3'd1 << t1_q) - 3'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_TOK;
      word_valid_o <= 1'b0;
      word_data_o  <= '0;
      word_len_o   <= '0;
      total_q      <= '0;
      lvl_left_q   <= '0;
      coef_left_q  <= '0;
      t1_q         <= '0;
      sign_q       <= '0;
      zeros_q      <= '0;
    end else begin
      if (word_valid_o && word_ready_i) word_valid_o <= 1'b0;
      unique case (state_q)
        ST_TOK: if (tok_valid_i && tok_ready_o) begin
          word_valid_o <= 1'b1;
          word_data_o  <= PAR_W'(tok_code_i);
          word_len_o   <= LEN_W'(tok_len_i);
          total_q      <= tok_total_i;
          t1_q         <= tok_t1_i;
          sign_q       <= tok_sign_i;
          lvl_left_q   <= tok_total_i - CW'(tok_t1_i);
          state_q      <= (tok_t1_i != 2'd0) ? ST_SGN
                        : after_sign(tok_total_i - CW'(tok_t1_i), tok_total_i);
        end
        ST_SGN: if (can_load) begin
          word_valid_o <= 1'b1;
          word_data_o  <= PAR_W'(sign_q & sign_mask);
          word_len_o   <= LEN_W'(t1_q);
          state_q      <= after_sign(lvl_left_q, total_q);
        end
        ST_LVL: if (lvl_valid_i && lvl_ready_o) begin
          word_valid_o <= 1'b1;
          word_data_o  <= lvl_word[PAR_W-1:0];
          word_len_o   <= LEN_W'(lvl_pre_len_i) + LEN_W'(lvl_suf_len_i) + LEN_W'(1);
          lvl_left_q   <= lvl_left_q - CW'(1);
          if (lvl_left_q == CW'(1))
            state_q <= (total_q < CW'(MAX_COEFF)) ? ST_TZ : ST_TOK;
        end
        ST_TZ: if (tz_valid_i && tz_ready_o) begin
          word_valid_o <= 1'b1;
          word_data_o  <= PAR_W'(tz_code_i);
          word_len_o   <= LEN_W'(tz_len_i);
          zeros_q      <= tz_value_i;
          coef_left_q  <= total_q;
          state_q      <= (tz_value_i != '0 && total_q > CW'(1)) ? ST_RUN : ST_TOK;
        end
        ST_RUN: if (run_valid_i && run_ready_o) begin
          word_valid_o <= 1'b1;
          word_data_o  <= PAR_W'(run_code_i);
          word_len_o   <= LEN_W'(run_len_i);
          zeros_q      <= zeros_nx;
          coef_left_q  <= coef_nx;
          state_q      <= (zeros_nx != '0 && coef_nx > CW'(1)) ? ST_RUN : ST_TOK;
        end
        default: state_q <= ST_TOK;
      endcase
    end
  end
endmodule

// File: rtl/cavlc_word_ser.sv
module cavlc_word_ser #(
  parameter int PAR_W = 21,
  parameter int LEN_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [PAR_W-1:0] in_data_i,
  input  logic [LEN_W-1:0] in_len_i,
  input  logic             halt_i,
  input  logic             full_i,
  output logic             push_o,
  output logic             bit_o
);
  logic [PAR_W-1:0] sh_q;
  logic [LEN_W-1:0] cnt_q;

  assign in_ready_o = (cnt_q == '0);
  assign push_o     = (cnt_q != '0) && !halt_i && !full_i;
  assign bit_o      = sh_q[PAR_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (in_valid_i && in_ready_o) begin
      sh_q  <= in_data_i << (LEN_W'(PAR_W) - in_len_i);  // left-align, MSB out first
      cnt_q <= in_len_i;
    end else if (push_o) begin
      sh_q  <= sh_q << 1;
      cnt_q <= cnt_q - LEN_W'(1);
    end
  end
endmodule

// File: rtl/cavlc_bit_fifo.sv
module cavlc_bit_fifo #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        push_i,
  input  logic        din_i,
  output logic        full_o,
  output logic        valid_o,
  input  logic        ready_i,
  output logic        dout_o,
  output logic [AW:0] cnt_o
);
  logic [DEPTH-1:0] mem_q;
  logic [AW-1:0]    wr_q, rd_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_o == (AW+1)'(DEPTH));
  assign valid_o = (cnt_o != '0);
  assign dout_o  = mem_q[rd_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = valid_o && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_o <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= din_i;
        wr_q        <= wr_q + AW'(1);
      end
      if (do_pop) rd_q <= rd_q + AW'(1);
      cnt_o <= cnt_o + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end
endmodule

// File: rtl/cavlc_stream_packer.sv
module cavlc_stream_packer #(
  parameter int PAR_W      = 21,
  parameter int MAX_COEFF  = 16,
  parameter int TOK_W      = 16,
  parameter int SUF_W      = 13,
  parameter int TZ_W       = 9,
  parameter int RUN_W      = 11,
  parameter int FIFO_DEPTH = 64,
  localparam int LEN_W     = $clog2(PAR_W + 1),
  localparam int CW        = $clog2(MAX_COEFF + 1),
  localparam int ZW        = $clog2(MAX_COEFF),
  localparam int FAW       = $clog2(FIFO_DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tok_valid_i,
  output logic             tok_ready_o,
  input  logic [TOK_W-1:0] tok_code_i,
  input  logic [4:0]       tok_len_i,
  input  logic [CW-1:0]    tok_total_i,
  input  logic [1:0]       tok_t1_i,
  input  logic [2:0]       tok_sign_i,
  input  logic             lvl_valid_i,
  output logic             lvl_ready_o,
  input  logic [3:0]       lvl_pre_len_i,
  input  logic [3:0]       lvl_suf_len_i,
  input  logic [SUF_W-1:0] lvl_suffix_i,
  input  logic             tz_valid_i,
  output logic             tz_ready_o,
  input  logic [TZ_W-1:0]  tz_code_i,
  input  logic [3:0]       tz_len_i,
  input  logic [ZW-1:0]    tz_value_i,
  input  logic             run_valid_i,
  output logic             run_ready_o,
  input  logic [RUN_W-1:0] run_code_i,
  input  logic [3:0]       run_len_i,
  input  logic [ZW-1:0]    run_value_i,
  input  logic             halt_i,
  output logic             par_valid_o,
  output logic [PAR_W-1:0] par_data_o,
  output logic [LEN_W-1:0] par_len_o,
  output logic             bit_o,
  output logic             bit_valid_o,
  input  logic             bit_ready_i
);
  logic           word_valid, ser_ready, ser_push, ser_bit, fifo_full;
  logic [FAW:0]   fill_cnt;

  assign par_valid_o = word_valid && ser_ready;

  cavlc_field_seq #(
    .PAR_W(PAR_W), .LEN_W(LEN_W), .MAX_COEFF(MAX_COEFF),
    .TOK_W(TOK_W), .SUF_W(SUF_W), .TZ_W(TZ_W), .RUN_W(RUN_W)
  ) seq_i (
    .clk_i, .rst_ni,
    .tok_valid_i, .tok_ready_o, .tok_code_i, .tok_len_i, .tok_total_i, .tok_t1_i, .tok_sign_i,
    .lvl_valid_i, .lvl_ready_o, .lvl_pre_len_i, .lvl_suf_len_i, .lvl_suffix_i,
    .tz_valid_i, .tz_ready_o, .tz_code_i, .tz_len_i, .tz_value_i,
    .run_valid_i, .run_ready_o, .run_code_i, .run_len_i, .run_value_i,
    .word_valid_o(word_valid), .word_ready_i(ser_ready),
    .word_data_o(par_data_o), .word_len_o(par_len_o)
  );

  cavlc_word_ser #(.PAR_W(PAR_W), .LEN_W(LEN_W)) ser_i (
    .clk_i, .rst_ni,
    .in_valid_i(word_valid), .in_ready_o(ser_ready),
    .in_data_i(par_data_o), .in_len_i(par_len_o),
    .halt_i, .full_i(fifo_full), .push_o(ser_push), .bit_o(ser_bit)
  );

  cavlc_bit_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i (
    .clk_i, .rst_ni,
    .push_i(ser_push), .din_i(ser_bit), .full_o(fifo_full),
    .valid_o(bit_valid_o), .ready_i(bit_ready_i), .dout_o(bit_o), .cnt_o(fill_cnt)
  );
endmodule

// File: rtl/cavlc_stream_packer_chk.sv
module cavlc_stream_packer_chk #(
  parameter int PAR_W      = 21,
  parameter int FIFO_DEPTH = 64,
  localparam int LEN_W     = $clog2(PAR_W + 1),
  localparam int FAW       = $clog2(FIFO_DEPTH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tok_ready_o,
  input logic             lvl_ready_o,
  input logic             tz_ready_o,
  input logic             run_ready_o,
  input logic             halt_i,
  input logic             par_valid_o,
  input logic [LEN_W-1:0] par_len_o,
  input logic [FAW:0]     fill_cnt
);
  // R10
  ready_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tok_ready_o, lvl_ready_o, tz_ready_o, run_ready_o}));
  // R8
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> (fill_cnt <= $past(fill_cnt)));
  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_cnt <= (FAW+1)'(FIFO_DEPTH));
  // R7
  par_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_valid_o |-> (par_len_o != '0 && par_len_o <= LEN_W'(PAR_W)));
  // R7
  par_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_valid_o |=> !par_valid_o);
endmodule

bind cavlc_stream_packer cavlc_stream_packer_chk #(
  .PAR_W(PAR_W), .FIFO_DEPTH(FIFO_DEPTH)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .tok_ready_o(tok_ready_o), .lvl_ready_o(lvl_ready_o),
  .tz_ready_o(tz_ready_o), .run_ready_o(run_ready_o),
  .halt_i(halt_i), .par_valid_o(par_valid_o), .par_len_o(par_len_o),
  .fill_cnt(fill_cnt)
);

// File: tb/cavlc_stream_packer_tb_top.sv
module cavlc_stream_packer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        tok_valid_i = 0, lvl_valid_i = 0, tz_valid_i = 0, run_valid_i = 0;
  logic [15:0] tok_code_i = '0;
  logic [4:0]  tok_len_i = '0, tok_total_i = '0;
  logic [1:0]  tok_t1_i = '0;
  logic [2:0]  tok_sign_i = '0;
  logic [3:0]  lvl_pre_len_i = '0, lvl_suf_len_i = '0;
  logic [12:0] lvl_suffix_i = '0;
  logic [8:0]  tz_code_i = '0;
  logic [3:0]  tz_len_i = '0, tz_value_i = '0;
  logic [10:0] run_code_i = '0;
  logic [3:0]  run_len_i = '0, run_value_i = '0;
  logic        halt_i = 0, bit_ready_i = 1;
  logic        tok_ready_o, lvl_ready_o, tz_ready_o, run_ready_o;
  logic        par_valid_o, bit_o, bit_valid_o;
  logic [20:0] par_data_o;
  logic [4:0]  par_len_o;

  int checks = 0, errors = 0;
  bit exp_bits [0:511];
  bit got_bits [0:511];
  int exp_n = 0, got_n = 0;
  int par_lens [0:63];
  int par_n = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cavlc_stream_packer dut_i (.*);

  always @(negedge clk_i) begin
    if (bit_valid_o && bit_ready_i && got_n < 512) begin
      got_bits[got_n] = bit_o;
      got_n++;
    end
    if (par_valid_o && par_n < 64) begin
      par_lens[par_n] = int'(par_len_o);
      par_n++;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    exp_n = 0; got_n = 0; par_n = 0;
  endtask

  task automatic push_exp(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      exp_bits[exp_n] = v[i];
      exp_n++;
    end
  endtask

  task automatic check_stream(input string req);
    int bad;
    for (int c = 0; c < 3000 && got_n < exp_n; c++) @(negedge clk_i);
    repeat (30) @(negedge clk_i);
    check(got_n == exp_n, req, "stream bit count", got_n, exp_n);
    bad = -1;
    for (int i = 0; i < exp_n && i < got_n; i++)
      if (bad < 0 && got_bits[i] != exp_bits[i]) bad = i;
    check(bad < 0, req, "first mismatching bit index", bad, -1);
  endtask

  task automatic send_tok(input logic [15:0] code, input int len, input int total, input int t1, input logic [2:0] sign);
    @(negedge clk_i);
    tok_valid_i = 1; tok_code_i = code; tok_len_i = 5'(len);
    tok_total_i = 5'(total); tok_t1_i = 2'(t1); tok_sign_i = sign;
    while (!tok_ready_o) @(negedge clk_i);
    @(posedge clk_i); #1 tok_valid_i = 0;
  endtask

  task automatic send_lvl(input int pre, input int sl, input logic [12:0] suf);
    @(negedge clk_i);
    lvl_valid_i = 1; lvl_pre_len_i = 4'(pre); lvl_suf_len_i = 4'(sl); lvl_suffix_i = suf;
    while (!lvl_ready_o) @(negedge clk_i);
    @(posedge clk_i); #1 lvl_valid_i = 0;
  endtask

  task automatic send_tz(input logic [8:0] code, input int len, input int val);
    @(negedge clk_i);
    tz_valid_i = 1; tz_code_i = code; tz_len_i = 4'(len); tz_value_i = 4'(val);
    while (!tz_ready_o) @(negedge clk_i);
    @(posedge clk_i); #1 tz_valid_i = 0;
  endtask

  task automatic send_run(input logic [10:0] code, input int len, input int val);
    @(negedge clk_i);
    run_valid_i = 1; run_code_i = code; run_len_i = 4'(len); run_value_i = 4'(val);
    while (!run_ready_o) @(negedge clk_i);
    @(posedge clk_i); #1 run_valid_i = 0;
  endtask

  // five coefficients, three trailing ones, total zeros 3
  task automatic send_example_rest();
    send_lvl(0, 0, 13'h0);
    send_lvl(3, 1, 13'h0);
    send_tz(9'b111, 3, 3);
    send_run(11'b10, 2, 1);
    send_run(11'b1, 1, 0);
    send_run(11'b1, 1, 0);
    send_run(11'b01, 2, 1);
  endtask

  task automatic exp_example();
    push_exp(32'b0000100, 7); push_exp(32'b011, 3);
    push_exp(32'b1, 1); push_exp(32'b00010, 5); push_exp(32'b111, 3);
    push_exp(32'b10, 2); push_exp(32'b1, 1); push_exp(32'b1, 1); push_exp(32'b01, 2);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    check(tok_ready_o == 1'b1, "R1", "tok_ready after reset", tok_ready_o, 1);
    check({lvl_ready_o, tz_ready_o, run_ready_o} == 3'b000, "R1", "other readies", {lvl_ready_o, tz_ready_o, run_ready_o}, 0);
    check(bit_valid_o == 1'b0 && par_valid_o == 1'b0, "R1", "outputs idle", {bit_valid_o, par_valid_o}, 0);
  endtask

  task automatic t_example();
    int lens [9] = '{7, 3, 1, 5, 3, 2, 1, 1, 2};
    clear_logs();
    exp_example();
    send_tok(16'b0000100, 7, 5, 3, 3'b011);
    send_example_rest();
    check_stream("R2");
    check(par_n == 9, "R7", "parallel word count", par_n, 9);
    for (int i = 0; i < 9; i++)
      check(par_lens[i] == lens[i], "R7", $sformatf("parallel word %0d length", i), par_lens[i], lens[i]);
    check(run_ready_o == 0 && tok_ready_o == 1, "R6", "run codes stop after zeros used", run_ready_o, 0);
  endtask

  task automatic t_empty();
    clear_logs();
    push_exp(32'b1, 1); push_exp(32'b1, 1);
    send_tok(16'b1, 1, 0, 0, 3'b000);
    send_tok(16'b1, 1, 0, 0, 3'b000);
    check_stream("R5");
    check(tz_ready_o == 0 && tok_ready_o == 1, "R5", "no zeros field for empty block", tz_ready_o, 0);
  endtask

  task automatic t_full();
    clear_logs();
    push_exp(32'b000101, 6);
    for (int i = 0; i < 16; i++) push_exp(32'b1, 1);
    send_tok(16'b000101, 6, 16, 0, 3'b111);
    for (int i = 0; i < 16; i++) send_lvl(0, 0, 13'h0);
    check_stream("R3");
    check(tz_ready_o == 0 && tok_ready_o == 1, "R5", "no zeros field at max count", tz_ready_o, 0);
  endtask

  task automatic t_tz0();
    clear_logs();
    push_exp(32'b001, 3); push_exp(32'b10, 2); push_exp(32'b1, 1);
    send_tok(16'b001, 3, 2, 2, 3'b110);
    send_tz(9'b1, 1, 0);
    check_stream("R3");
    check(run_ready_o == 0 && tok_ready_o == 1, "R6", "no runs when total zeros is 0", run_ready_o, 0);
  endtask

  task automatic t_level_mask();
    clear_logs();
    push_exp(32'b01, 2); push_exp(32'b001101, 6); push_exp(32'b011, 3);
    send_tok(16'b01, 2, 1, 0, 3'b000);
    send_lvl(2, 3, 13'h1FD);
    send_tz(9'b011, 3, 5);
    check_stream("R4");
    check(run_ready_o == 0, "R6", "no run for single coefficient", run_ready_o, 0);
  endtask

  task automatic t_halt();
    clear_logs();
    exp_example();
    halt_i = 1;
    send_tok(16'b0000100, 7, 5, 3, 3'b011);
    repeat (40) @(negedge clk_i);
    check(bit_valid_o == 0 && got_n == 0, "R8", "bits while halted", got_n, 0);
    check(lvl_ready_o == 0, "R8", "level input stalled by halt", lvl_ready_o, 0);
    @(posedge clk_i); #1 halt_i = 0;
    send_example_rest();
    check_stream("R8");
  endtask

  task automatic t_fifo_full();
    clear_logs();
    for (int b = 0; b < 3; b++) exp_example();
    @(posedge clk_i); #1 bit_ready_i = 0;
    fork
      for (int b = 0; b < 3; b++) begin
        send_tok(16'b0000100, 7, 5, 3, 3'b011);
        send_example_rest();
      end
    join_none
    repeat (300) @(negedge clk_i);
    check(bit_valid_o == 1 && got_n == 0, "R9", "FIFO holds bits while blocked", bit_valid_o, 1);
    check(tok_ready_o == 0 && run_ready_o == 0, "R9", "inputs stalled when FIFO full", run_ready_o, 0);
    @(posedge clk_i); #1 bit_ready_i = 1;
    wait fork;
    check_stream("R9");
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    t_reset();
    t_example();
    t_empty();
    t_full();
    t_tz0();
    t_level_mask();
    t_halt();
    t_fifo_full();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule